// File: doc/BRIEF.md
# Divider Setting Loader for a Clock Synthesizer

This block holds the active feedback value, post-divider code and test-select field for a frequency synthesizer. Two ports can write them. The parallel port is level sensitive. While its load control is low, the feedback and post-divider inputs flow straight through to the active registers, and the test field is held at zero. On the rising edge of that control the values are frozen. While the control stays high, the serial port is enabled. A bit stream is clocked into a shift register, and the falling edge of a separate load strobe copies the whole word into the active registers.

Every input is sampled on the system clock, `clk`. Edges on the load control, the serial clock and the load strobe are found by comparing each input with its value one cycle earlier. The post-divider code is also decoded into the divide ratio it selects. A one-cycle pulse marks each commit.

Top module: `cfg_loader`

## Requirements
- R1: While reset is asserted, the active feedback value, post-divider code and test field are all zero. The shift register is zero, `n_div` is 2 and `config_changed` is low.
- R2: In every cycle where `p_load` is low, `m_out` and `n_code` take the values on `par_m` and `par_n` at the next clock edge. Each input change appears one cycle later.
- R3: In the cycle where `p_load` first reads high, the values on `par_m` and `par_n` are captured. While `p_load` stays high, later changes on `par_m` and `par_n` do not affect the outputs.
- R4: A rising edge on `ser_clk` shifts `ser_data` into the shift register only while `p_load` is high. Serial clock edges while `p_load` is low leave the shift register unchanged.
- R5: The stream is 12 bits long: first the 3 test bits, then the 2 post-divider bits, then the 7 feedback bits, each field MSB first. After 12 shifts, bits [11:9] are the test field, bits [8:7] the post-divider code and bits [6:0] the feedback value.
- R6: Shifting does not change the active registers. A falling edge on `ser_load`, seen while `p_load` is high, copies the shift register into the active registers at that clock edge.
- R7: In any cycle after `p_load` has been low, `t_out` reads 000. The parallel port never sets the test field.
- R8: `n_div` gives the divide ratio for `n_code`: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 1.
- R9: `config_changed` is high for exactly one cycle. That cycle follows a `p_load` rising edge or a serial commit, and it is the cycle in which the new values first appear. It is low otherwise.
- R10: If a `p_load` rising edge and a `ser_load` falling edge fall in the same cycle, the parallel capture wins and the serial word is discarded.
- R11: If a `ser_clk` rising edge and a `ser_load` falling edge fall in the same cycle, the commit uses the word from before that shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_load | input | 1 | Parallel load control: low is transparent, rising edge captures |
| par_m | input | 7 | Parallel feedback value |
| par_n | input | 2 | Parallel post-divider code |
| ser_clk | input | 1 | Serial shift clock, sampled on clk |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial commit strobe, acts on its falling edge |
| m_out | output | 7 | Active feedback value |
| n_code | output | 2 | Active post-divider code |
| n_div | output | 4 | Divide ratio decoded from n_code |
| t_out | output | 3 | Active test-select field |
| config_changed | output | 1 | One-cycle commit pulse |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is the parallel capture and the serial commit. To provoke it, a word is shifted in with the strobe held high, `p_load` is dropped, and then `p_load` is raised in the same cycle that the strobe is released. The outputs must show the parallel values with a zero test field. They must stay that way afterwards, and exactly one change pulse is expected.

The second pair is a shift and a commit. To provoke it, the serial clock rises in the same cycle that the strobe falls. The committed word must be the one that existed before that extra bit arrived.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CFG_M_W = 7;
  localparam int CFG_N_W = 2;
  localparam int CFG_T_W = 3;

  // post-divider code to divide ratio
  function automatic logic [3:0] ndiv_of(input logic [1:0] code);
    logic [3:0] r;
    case (code)
      2'b00:   r = 4'd2;
      2'b01:   r = 4'd4;
      2'b10:   r = 4'd8;
      default: r = 4'd1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/edge_pulse.sv
module edge_pulse #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse = prev_q & ~sig;
    end else begin : g_rise
      assign pulse = ~prev_q & sig;
    end
  endgenerate

  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] word
);
  logic [W-1:0] sh_q;
  wire          shift_now = en & step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sh_q <= '0;
    else if (shift_now) sh_q <= {sh_q[W-2:0], din};
  end

  assign word = sh_q;

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(word));
  p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_now |=> (word == {$past(word[W-2:0]), $past(din)}));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs #(
  parameter int M_W = 7,
  parameter int N_W = 2,
  parameter int T_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_take,
  input  logic           par_commit,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_commit,
  input  logic [T_W-1:0] ser_t,
  input  logic [N_W-1:0] ser_n,
  input  logic [M_W-1:0] ser_m,
  output logic [M_W-1:0] m_q,
  output logic [N_W-1:0] n_q,
  output logic [T_W-1:0] t_q,
  output logic           changed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      n_q <= '0;
      t_q <= '0;
    end else if (par_take) begin
      m_q <= par_m;
      n_q <= par_n;
      t_q <= '0;
    end else if (ser_commit) begin
      m_q <= ser_m;
      n_q <= ser_n;
      t_q <= ser_t;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) changed <= 1'b0;
    else        changed <= par_commit | ser_commit;
  end

  p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    par_take |=> (m_q == $past(par_m)) && (n_q == $past(par_n)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_take && !ser_commit) |=> ($stable(m_q) && $stable(n_q) && $stable(t_q)));
  p_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_commit |=> (m_q == $past(ser_m)) && (n_q == $past(ser_n)) && (t_q == $past(ser_t)));
  p_pulse_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (par_commit || ser_commit) |=> changed);
  p_pulse_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(par_commit || ser_commit) |=> !changed);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(par_take && ser_commit));
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_pkg::*;
#(
  parameter int M_W = CFG_M_W,
  parameter int T_W = CFG_T_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           p_load,
  input  logic [M_W-1:0] par_m,
  input  logic [1:0]     par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [M_W-1:0] m_out,
  output logic [1:0]     n_code,
  output logic [3:0]     n_div,
  output logic [T_W-1:0] t_out,
  output logic           config_changed
);
  localparam int N_W  = CFG_N_W;
  localparam int SH_W = T_W + N_W + M_W;

  // internal events, named for the checks
  logic p_rise;
  logic sclk_rise;
  logic sload_fall;
  logic par_take;
  logic ser_commit;
  logic [SH_W-1:0] sh_word;

  edge_pulse #(.FALLING(1'b0)) u_prise (
    .clk(clk), .rst_n(rst_n), .sig(p_load), .pulse(p_rise));
  edge_pulse #(.FALLING(1'b0)) u_srise (
    .clk(clk), .rst_n(rst_n), .sig(ser_clk), .pulse(sclk_rise));
  edge_pulse #(.FALLING(1'b1)) u_lfall (
    .clk(clk), .rst_n(rst_n), .sig(ser_load), .pulse(sload_fall));

  // transparent while low, and the capture cycle itself
  assign par_take   = ~p_load | p_rise;
  // parallel capture takes priority over a serial commit
  assign ser_commit = p_load & sload_fall & ~p_rise;

  cfg_shifter #(.W(SH_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(p_load), .step(sclk_rise),
    .din(ser_data), .word(sh_word));

  cfg_regs #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .par_take(par_take), .par_commit(p_rise),
    .par_m(par_m), .par_n(par_n),
    .ser_commit(ser_commit),
    .ser_t(sh_word[SH_W-1 -: T_W]),
    .ser_n(sh_word[M_W +: N_W]),
    .ser_m(sh_word[M_W-1:0]),
    .m_q(m_out), .n_q(n_code), .t_q(t_out),
    .changed(config_changed));

  assign n_div = ndiv_of(n_code);

  p_tzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !p_load |=> (t_out == '0));
  p_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(n_div) == 1);
  p_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rise && sload_fall) |=> (t_out == '0) && (m_out == $past(par_m)));
endmodule

// File: tb/sim_cfg_loader.sv
module sim_cfg_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       p_load = 1'b0;
  logic [6:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic       ser_load = 1'b0;
  logic [6:0] m_out;
  logic [1:0] n_code;
  logic [3:0] n_div;
  logic [2:0] t_out;
  logic       config_changed;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_loader u0 (
    .clk(clk), .rst_n(rst_n), .p_load(p_load), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .m_out(m_out), .n_code(n_code), .n_div(n_div), .t_out(t_out),
    .config_changed(config_changed));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b;
    ser_clk = 1'b1;
    tick();
    ser_clk = 1'b0;
    tick();
  endtask

  task automatic send(input logic [2:0] t, input logic [1:0] n, input logic [6:0] m);
    logic [11:0] w;
    w = {t, n, m};
    for (int i = 11; i >= 0; i--) shift_bit(w[i]);
  endtask

  // strobe high then low; returns in the cycle the commit is visible
  task automatic commit();
    ser_load = 1'b1;
    tick();
    ser_load = 1'b0;
    tick();
  endtask

  function automatic int ratio(input int code);
    return 1 << ((code + 1) % 4);
  endfunction

  task automatic t_reset();
    check("R1 m", m_out, 0);
    check("R1 n", n_code, 0);
    check("R1 t", t_out, 0);
    check("R1 div", n_div, 2);
    check("R1 chg", config_changed, 0);
  endtask

  task automatic t_transparent();
    par_m = 7'd48; par_n = 2'b01;
    tick();
    check("R2 m", m_out, 48);
    check("R2 n", n_code, 1);
    par_m = 7'd100; par_n = 2'b10;
    tick();
    check("R2 m2", m_out, 100);
    check("R2 chg", config_changed, 0);
  endtask

  task automatic t_freeze();
    par_m = 7'd25; par_n = 2'b11;
    p_load = 1'b1;
    tick();
    check("R3 m", m_out, 25);
    check("R3 n", n_code, 3);
    check("R9 pulse", config_changed, 1);
    par_m = 7'd90; par_n = 2'b00;
    tick();
    check("R9 drop", config_changed, 0);
    tick();
    check("R3 hold m", m_out, 25);
    check("R3 hold n", n_code, 3);
  endtask

  task automatic t_serial();
    send(3'b101, 2'b10, 7'b0110001);
    check("R6 pre m", m_out, 25);
    check("R6 pre t", t_out, 0);
    ser_load = 1'b1;
    tick();
    ser_load = 1'b0;
    tick();
    check("R5 m", m_out, 7'b0110001);
    check("R5 n", n_code, 2);
    check("R5 t", t_out, 5);
    check("R9 ser pulse", config_changed, 1);
    tick();
    check("R9 ser drop", config_changed, 0);
  endtask

  task automatic t_tzero();
    p_load = 1'b0;
    par_m = 7'd56; par_n = 2'b00;
    tick();
    check("R7 t", t_out, 0);
    check("R7 m", m_out, 56);
  endtask

  task automatic t_ignore_low();
    // p_load low: these shifts must be lost
    send(3'b111, 2'b11, 7'h7f);
    par_m = 7'd30; par_n = 2'b01;
    p_load = 1'b1;
    tick();
    send(3'b010, 2'b01, 7'd5); // puts a known word in
    p_load = 1'b0; tick();
    send(3'b111, 2'b11, 7'h7f); // ignored
    p_load = 1'b1; tick();
    commit();
    check("R4 m", m_out, 5);
    check("R4 n", n_code, 1);
    check("R4 t", t_out, 2);
  endtask

  task automatic t_decode();
    p_load = 1'b0;
    for (int c = 0; c < 4; c++) begin
      par_n = c[1:0];
      tick();
      check("R8 div", n_div, ratio(c));
    end
  endtask

  task automatic t_collide_par();
    p_load = 1'b1; tick();
    send(3'b011, 2'b10, 7'd77);
    ser_load = 1'b1; tick();
    p_load = 1'b0; par_m = 7'd33; par_n = 2'b11; tick();
    p_load = 1'b1; ser_load = 1'b0;
    tick();
    check("R10 m", m_out, 33);
    check("R10 t", t_out, 0);
    check("R10 chg", config_changed, 1);
    tick();
    check("R10 after m", m_out, 33);
    check("R10 after chg", config_changed, 0);
  endtask

  task automatic t_collide_shift();
    send(3'b001, 2'b01, 7'd64);
    ser_load = 1'b1; tick();
    ser_load = 1'b0; ser_clk = 1'b1; ser_data = 1'b1;
    tick();
    ser_clk = 1'b0;
    check("R11 m", m_out, 64);
    check("R11 t", t_out, 1);
    check("R11 n", n_code, 1);
    tick();
  endtask

  initial begin
    tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_transparent();
    t_freeze();
    t_serial();
    t_tzero();
    t_ignore_low();
    t_decode();
    t_collide_par();
    t_collide_shift();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule